// File: doc/BRIEF.md
# Nested Priority Interrupt Controller

This block sits between a set of interrupt sources and a processor core. Each source raises a request by a rising edge on its input. The controller records the edge as a pending flag and chooses the most urgent pending source that is enabled. It presents that source's vector straight to the core, so software never has to search for the source. One extra input is a non-maskable request. It gets its own vector, one above the highest source index.

The controller keeps a running level for the handler now executing and saves the levels of any handlers it has preempted. A maskable source is offered to the core only when the global mask is off and the source is strictly more urgent than the running handler. Anything else stays pending until the blocking condition clears. The core accepts an offered vector with an acknowledge pulse and ends a handler with a return pulse. The return pulse restores the level of the interrupted handler.

Levels use a single encoding. The non-maskable handler runs at level 0. A maskable source with priority p runs at level p+1. When no handler is active the level reads all ones (15 with the default three-bit priorities). A smaller level is more urgent.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset no vector is offered (`int_req` low) and `run_lvl` reads the idle value 15.
- R2: A rising edge on `irq_in[i]` is caught at the clock edge that first samples it high. With nothing blocking, `int_req` is high and `int_vec` equals i right after that same clock edge.
- R3: Among pending and enabled sources, the one with the smallest 3-bit priority field in `src_prio[3*i+2:3*i]` wins. On equal priority the lower index wins. `int_vec` carries the source index, from 0 to 7.
- R4: While `glb_mask` is 1, no maskable source is offered. Its pending flag is kept, and the source is offered once the mask is cleared.
- R5: A pending source whose `src_en` bit is 0 is not offered. It is offered once the bit is set.
- R6: A clock edge with `int_req` and `int_ack` high and `hdl_ret` low takes the offered vector. The source's pending flag is cleared, and `run_lvl` becomes p+1, or 0 for the non-maskable vector 8.
- R7: A maskable source is offered only if p+1 is strictly below `run_lvl`. A source of equal or lower urgency stays pending until the running handler returns.
- R8: A `hdl_ret` pulse restores the level of the most recently preempted handler, in last-in first-out order, or the idle value when there is none. When `hdl_ret` and `int_ack` are high in the same cycle, the return is carried out and the acknowledge is ignored.
- R9: A rising edge on `nmi_in` is offered as vector 8, regardless of the mask, the enables and the running level, unless the non-maskable handler itself is running (`run_lvl` = 0). In that case it is held until that handler returns.
- R10: A new edge on a source while its own handler is running sets the pending flag again. The source is offered once the level allows.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_in | input | N_SRC | Source request lines, edge detected |
| nmi_in | input | 1 | Non-maskable request line, edge detected |
| src_en | input | N_SRC | Per-source enable |
| src_prio | input | N_SRC*PRIO_W | Per-source priority fields, lower is more urgent |
| glb_mask | input | 1 | Global mask for maskable sources |
| int_req | output | 1 | A vector is being offered to the core |
| int_vec | output | $clog2(N_SRC+1) | Offered vector, N_SRC for non-maskable |
| int_ack | input | 1 | Core takes the offered vector |
| hdl_ret | input | 1 | Core leaves the current handler |
| run_lvl | output | PRIO_W+1 | Level of the running handler, all ones when idle |

## Verification
The arbiter is swept over every pair of sources arriving in the same cycle, under a set of distinct priorities and under all-equal priorities. The first shows that the smallest field wins and the second shows that the lower index breaks ties. The nesting rule is swept over all 64 combinations of running priority and new priority, which separates strict preemption from holding on equal or lower urgency. A chain of eight nested handlers topped by a non-maskable one checks the last-in first-out unwinding. Directed cases cover the mask, the enables, non-maskable re-entry, re-arming during a handler, and an acknowledge that coincides with a return.

// File: rtl/pic_pkg.sv
package pic_pkg;
  typedef enum logic [1:0] {
    STK_HOLD = 2'd0,
    STK_PUSH = 2'd1,
    STK_POP  = 2'd2
  } stk_op_e;
endpackage

// File: rtl/pic_pending.sv
// Edge capture and pending flags, one slice per request line.
module pic_pending #(
  parameter int W = 9
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] req_in,
  input  logic [W-1:0] clr_in,
  output logic [W-1:0] pend_o
);
  logic [W-1:0] req_q;
  logic [W-1:0] pend_q;
  logic [W-1:0] pend_d;
  logic [W-1:0] rise;
  logic [W-1:0] upd_en;

  for (genvar g = 0; g < W; g++) begin : g_slice
    always_comb begin
      rise[g]   = req_in[g] & ~req_q[g];
      upd_en[g] = rise[g] | clr_in[g];
      // a fresh edge wins over a clear in the same cycle
      pend_d[g] = rise[g] | (pend_q[g] & ~clr_in[g]);
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        req_q[g]  <= 1'b0;
        pend_q[g] <= 1'b0;
      end else begin
        req_q[g] <= req_in[g];
        if (upd_en[g]) pend_q[g] <= pend_d[g];
      end
    end
  end

  assign pend_o = pend_q;
endmodule

// File: rtl/pic_arbiter.sv
// Picks the most urgent eligible source; ascending scan with strict compare
// makes the lower index win a tie.
module pic_arbiter #(
  parameter int N_SRC  = 8,
  parameter int PRIO_W = 3,
  parameter int IDX_W  = 4
) (
  input  logic [N_SRC-1:0]        elig_in,
  input  logic [N_SRC*PRIO_W-1:0] prio_in,
  output logic                    any_o,
  output logic [IDX_W-1:0]        idx_o,
  output logic [PRIO_W-1:0]       prio_o
);
  always_comb begin
    any_o  = 1'b0;
    idx_o  = '0;
    prio_o = '1;
    for (int i = 0; i < N_SRC; i++) begin
      if (elig_in[i] && (!any_o || (prio_in[i*PRIO_W +: PRIO_W] < prio_o))) begin
        any_o  = 1'b1;
        idx_o  = IDX_W'(i);
        prio_o = prio_in[i*PRIO_W +: PRIO_W];
      end
    end
  end
endmodule

// File: rtl/pic_lvl_stack.sv
// Running level plus a stack of preempted levels.
module pic_lvl_stack
  import pic_pkg::*;
#(
  parameter int             DEPTH    = 8,
  parameter int             LVL_W    = 4,
  parameter logic [LVL_W-1:0] IDLE_LVL = '1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  stk_op_e          op_in,
  input  logic [LVL_W-1:0] push_lvl,
  output logic [LVL_W-1:0] cur_o
);
  localparam int CW = $clog2(DEPTH + 1);

  logic [LVL_W-1:0] mem_q [DEPTH];
  logic [CW-1:0]    cnt_q, cnt_d;
  logic [LVL_W-1:0] cur_q, cur_d;
  logic [LVL_W-1:0] top_lvl;
  logic             wr_en;
  logic             st_en;

  always_comb begin
    top_lvl = IDLE_LVL;
    for (int i = 0; i < DEPTH; i++) begin
      if (cnt_q == CW'(i + 1)) top_lvl = mem_q[i];
    end
  end

  always_comb begin
    cnt_d = cnt_q;
    cur_d = cur_q;
    wr_en = 1'b0;
    st_en = 1'b0;
    unique case (op_in)
      STK_PUSH: begin
        st_en = 1'b1;
        cur_d = push_lvl;
        if (cur_q != IDLE_LVL && cnt_q != CW'(DEPTH)) begin
          wr_en = 1'b1;
          cnt_d = cnt_q + CW'(1);
        end
      end
      STK_POP: begin
        st_en = 1'b1;
        if (cnt_q != '0) begin
          cur_d = top_lvl;
          cnt_d = cnt_q - CW'(1);
        end else begin
          cur_d = IDLE_LVL;
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_q <= IDLE_LVL;
      cnt_q <= '0;
    end else if (st_en) begin
      cur_q <= cur_d;
      cnt_q <= cnt_d;
    end
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_entry
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        mem_q[g] <= '0;
      end else if (wr_en && cnt_q == CW'(g)) begin
        mem_q[g] <= cur_q;
      end
    end
  end

  assign cur_o = cur_q;
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
  import pic_pkg::*;
#(
  parameter int N_SRC     = 8,
  parameter int PRIO_W    = 3,
  parameter int STK_DEPTH = 8
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [N_SRC-1:0]              irq_in,
  input  logic                          nmi_in,
  input  logic [N_SRC-1:0]              src_en,
  input  logic [N_SRC*PRIO_W-1:0]       src_prio,
  input  logic                          glb_mask,
  output logic                          int_req,
  output logic [$clog2(N_SRC+1)-1:0]    int_vec,
  input  logic                          int_ack,
  input  logic                          hdl_ret,
  output logic [PRIO_W:0]               run_lvl
);
  localparam int               VEC_W    = $clog2(N_SRC + 1);
  localparam int               LVL_W    = PRIO_W + 1;
  localparam logic [LVL_W-1:0] LVL_IDLE = '1;
  localparam logic [LVL_W-1:0] LVL_NMI  = '0;
  localparam logic [VEC_W-1:0] VEC_NMI  = VEC_W'(N_SRC);

  logic [N_SRC:0]      pend;
  logic [N_SRC:0]      clr;
  logic [N_SRC-1:0]    elig;
  logic                win_any;
  logic [VEC_W-1:0]    win_idx;
  logic [PRIO_W-1:0]   win_prio;
  logic [LVL_W-1:0]    win_lvl;
  logic [LVL_W-1:0]    cur_lvl;
  logic                nmi_ok;
  logic                mask_ok;
  logic                take;
  stk_op_e             stk_op;
  logic [LVL_W-1:0]    push_lvl;

  pic_pending #(.W(N_SRC + 1)) u_pend (
    .clk    (clk),
    .rst_n  (rst_n),
    .req_in ({nmi_in, irq_in}),
    .clr_in (clr),
    .pend_o (pend)
  );

  assign elig = pend[N_SRC-1:0] & src_en;

  pic_arbiter #(.N_SRC(N_SRC), .PRIO_W(PRIO_W), .IDX_W(VEC_W)) u_arb (
    .elig_in (elig),
    .prio_in (src_prio),
    .any_o   (win_any),
    .idx_o   (win_idx),
    .prio_o  (win_prio)
  );

  always_comb begin
    win_lvl = {1'b0, win_prio} + LVL_W'(1);
    nmi_ok  = pend[N_SRC] && (cur_lvl != LVL_NMI);
    mask_ok = win_any && !glb_mask && (win_lvl < cur_lvl);
    int_req = nmi_ok || mask_ok;
    int_vec = nmi_ok ? VEC_NMI : win_idx;
    take    = int_req && int_ack && !hdl_ret;
  end

  always_comb begin
    for (int i = 0; i <= N_SRC; i++) begin
      clr[i] = take && (int_vec == VEC_W'(i));
    end
  end

  always_comb begin
    push_lvl = nmi_ok ? LVL_NMI : win_lvl;
    if (hdl_ret)   stk_op = STK_POP;
    else if (take) stk_op = STK_PUSH;
    else           stk_op = STK_HOLD;
  end

  pic_lvl_stack #(.DEPTH(STK_DEPTH), .LVL_W(LVL_W), .IDLE_LVL(LVL_IDLE)) u_stk (
    .clk      (clk),
    .rst_n    (rst_n),
    .op_in    (stk_op),
    .push_lvl (push_lvl),
    .cur_o    (cur_lvl)
  );

  assign run_lvl = cur_lvl;
endmodule

// File: rtl/prio_irq_ctrl_chk.sv
module prio_irq_ctrl_chk #(
  parameter int N_SRC  = 8,
  parameter int PRIO_W = 3
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       nmi_in,
  input logic [N_SRC-1:0]           src_en,
  input logic [N_SRC*PRIO_W-1:0]    src_prio,
  input logic                       glb_mask,
  input logic                       int_req,
  input logic [$clog2(N_SRC+1)-1:0] int_vec,
  input logic                       int_ack,
  input logic                       hdl_ret,
  input logic [PRIO_W:0]            run_lvl
);
  localparam int               VEC_W = $clog2(N_SRC + 1);
  localparam int               LVL_W = PRIO_W + 1;
  localparam logic [VEC_W-1:0] VNMI  = VEC_W'(N_SRC);
  localparam logic [LVL_W-1:0] IDLE  = '1;

  logic              vec_en;
  logic [LVL_W-1:0]  vec_lvl;
  logic              src_offer;

  always_comb begin
    vec_en  = 1'b0;
    vec_lvl = '0;
    for (int i = 0; i < N_SRC; i++) begin
      if (int_vec == VEC_W'(i)) begin
        vec_en  = src_en[i];
        vec_lvl = {1'b0, src_prio[i*PRIO_W +: PRIO_W]} + LVL_W'(1);
      end
    end
    src_offer = int_req && (int_vec != VNMI);
  end

  AST_VEC_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    int_req |-> int_vec <= VNMI); // R3

  AST_MASK_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    src_offer |-> !glb_mask); // R4

  AST_EN_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    src_offer |-> vec_en); // R5

  AST_TAKE_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    (int_req && int_ack && !hdl_ret) |=> run_lvl == (($past(int_vec) == VNMI) ? '0 : $past(vec_lvl))); // R6

  AST_STRICT_NEST: assert property (@(posedge clk) disable iff (!rst_n)
    src_offer |-> vec_lvl < run_lvl); // R7

  AST_RET_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (hdl_ret && run_lvl == IDLE) |=> run_lvl == IDLE); // R8

  AST_NMI_NO_REENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    (run_lvl == '0) |-> !(int_req && int_vec == VNMI)); // R9

  AST_NMI_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(nmi_in) && run_lvl != '0 && !(int_ack && int_vec == VNMI))
      |=> (int_req && int_vec == VNMI)); // R9
endmodule

bind prio_irq_ctrl prio_irq_ctrl_chk #(.N_SRC(N_SRC), .PRIO_W(PRIO_W)) i_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .nmi_in   (nmi_in),
  .src_en   (src_en),
  .src_prio (src_prio),
  .glb_mask (glb_mask),
  .int_req  (int_req),
  .int_vec  (int_vec),
  .int_ack  (int_ack),
  .hdl_ret  (hdl_ret),
  .run_lvl  (run_lvl)
);

// File: tb/test_prio_irq_ctrl.sv
module test_prio_irq_ctrl;
  localparam int N    = 8;
  localparam int PW   = 3;
  localparam int IDLE = 15;
  localparam int VNMI = 8;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic [N-1:0]   irq_in = '0;
  logic           nmi_in = 1'b0;
  logic [N-1:0]   src_en = '1;
  logic [N*PW-1:0] src_prio = '0;
  logic           glb_mask = 1'b0;
  logic           int_req;
  logic [3:0]     int_vec;
  logic           int_ack = 1'b0;
  logic           hdl_ret = 1'b0;
  logic [3:0]     run_lvl;

  int nchk = 0;
  int nerr = 0;
  int cyc  = 0;
  int pa [N];

  always #10 clk = ~clk;

  prio_irq_ctrl #(.N_SRC(N), .PRIO_W(PW), .STK_DEPTH(8)) i_prio_irq_ctrl (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .nmi_in(nmi_in),
    .src_en(src_en), .src_prio(src_prio), .glb_mask(glb_mask),
    .int_req(int_req), .int_vec(int_vec), .int_ack(int_ack),
    .hdl_ret(hdl_ret), .run_lvl(run_lvl)
  );

  task automatic chk(input int act, input int exp, input string tag);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic pulse(input logic [N-1:0] b);
    irq_in = b;
    tick();
    irq_in = '0;
  endtask

  task automatic pulse_nmi();
    nmi_in = 1'b1;
    tick();
    nmi_in = 1'b0;
  endtask

  task automatic take();
    int_ack = 1'b1;
    tick();
    int_ack = 1'b0;
  endtask

  task automatic ret_h();
    hdl_ret = 1'b1;
    tick();
    hdl_ret = 1'b0;
  endtask

  task automatic set_prio(input int k, input int p);
    src_prio[k*PW +: PW] = PW'(p);
  endtask

  task automatic drain();
    glb_mask = 1'b0;
    src_en   = '1;
    for (int n = 0; n < 40; n++) begin
      if (int_req) take();
      else if (int'(run_lvl) != IDLE) ret_h();
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 100000) begin
      nchk++;
      nerr++;
      $display("FAIL watchdog: actual %0d expected below %0d cycles", cyc, 100000);
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(int'(int_req), 0, "R1 req during reset");
    rst_n = 1'b1;
    tick();
    chk(int'(int_req), 0, "R1 req after reset");
    chk(int'(run_lvl), IDLE, "R1 idle level");

    // R2 / R6 / R8: each source alone
    for (int k = 0; k < N; k++) set_prio(k, 3);
    for (int i = 0; i < N; i++) begin
      irq_in = N'(1) << i;
      chk(int'(int_req), 0, "R2 nothing before edge sampled");
      tick();
      irq_in = '0;
      chk(int'(int_req), 1, "R2 req one cycle after edge");
      chk(int'(int_vec), i, "R2 vector");
      take();
      chk(int'(run_lvl), 4, "R6 level after take");
      chk(int'(int_req), 0, "R6 pending cleared");
      ret_h();
      chk(int'(run_lvl), IDLE, "R8 idle after return");
    end

    // R3: pairwise sweep, distinct then equal priorities
    for (int pass = 0; pass < 2; pass++) begin
      for (int k = 0; k < N; k++) begin
        pa[k] = (pass == 0) ? (k * 3 + 1) % 8 : 5;
        set_prio(k, pa[k]);
      end
      for (int i = 0; i < N; i++) begin
        for (int j = i + 1; j < N; j++) begin
          pulse((N'(1) << i) | (N'(1) << j));
          chk(int'(int_vec), (pa[j] < pa[i]) ? j : i, "R3 pair winner");
          drain();
        end
      end
    end
    for (int k = 0; k < N; k++) set_prio(k, (k * 3 + 1) % 8);
    pulse('1);
    chk(int'(int_vec), 5, "R3 all sources winner");
    drain();

    // R7 / R8: nesting sweep
    for (int r = 0; r < 8; r++) begin
      for (int q = 0; q < 8; q++) begin
        set_prio(2, r);
        set_prio(5, q);
        pulse(N'(1) << 2);
        take();
        chk(int'(run_lvl), r + 1, "R6 running level");
        pulse(N'(1) << 5);
        chk(int'(int_req), (q < r) ? 1 : 0, "R7 preempt only if strictly higher");
        if (q < r) begin
          chk(int'(int_vec), 5, "R7 preempting vector");
          take();
          chk(int'(run_lvl), q + 1, "R7 nested level");
          ret_h();
          chk(int'(run_lvl), r + 1, "R8 restore preempted level");
        end else begin
          ret_h();
          chk(int'(int_req), 1, "R7 held request after return");
          chk(int'(int_vec), 5, "R7 held vector after return");
        end
        drain();
      end
    end

    // R4 mask, with R9 under mask
    for (int k = 0; k < N; k++) set_prio(k, 2);
    glb_mask = 1'b1;
    pulse(N'(1) << 3);
    chk(int'(int_req), 0, "R4 masked source not offered");
    tick();
    chk(int'(int_req), 0, "R4 still held");
    pulse_nmi();
    chk(int'(int_req), 1, "R9 nmi ignores mask");
    chk(int'(int_vec), VNMI, "R9 nmi vector");
    take();
    chk(int'(run_lvl), 0, "R6 nmi level");
    ret_h();
    chk(int'(int_req), 0, "R4 masked after nmi");
    glb_mask = 1'b0;
    tick();
    chk(int'(int_vec), 3, "R4 offered after unmask");
    chk(int'(int_req), 1, "R4 req after unmask");
    drain();

    // R5 enables
    src_en[6] = 1'b0;
    pulse(N'(1) << 6);
    chk(int'(int_req), 0, "R5 disabled source held");
    src_en[6] = 1'b1;
    tick();
    chk(int'(int_req), 1, "R5 offered after enable");
    chk(int'(int_vec), 6, "R5 vector after enable");
    drain();

    // R9: preempt level 1, no re-entry
    set_prio(0, 0);
    pulse(N'(1));
    take();
    chk(int'(run_lvl), 1, "R6 most urgent source level");
    src_en = '0;
    pulse_nmi();
    chk(int'(int_vec), VNMI, "R9 nmi preempts level 1 with enables off");
    take();
    pulse_nmi();
    chk(int'(int_req), 0, "R9 nmi held during nmi handler");
    ret_h();
    chk(int'(run_lvl), 1, "R8 back to level 1");
    chk(int'(int_req), 1, "R9 second nmi offered");
    chk(int'(int_vec), VNMI, "R9 second nmi vector");
    drain();

    // R10 re-arm during own handler, R8 ack with return
    set_prio(4, 4);
    set_prio(1, 0);
    pulse(N'(1) << 4);
    take();
    pulse(N'(1) << 4);
    chk(int'(int_req), 0, "R10 rearmed source held at equal level");
    ret_h();
    chk(int'(int_vec), 4, "R10 rearmed source offered");
    take();
    pulse(N'(1) << 1);
    chk(int'(int_vec), 1, "R7 urgent source offered");
    int_ack = 1'b1;
    hdl_ret = 1'b1;
    tick();
    int_ack = 1'b0;
    hdl_ret = 1'b0;
    chk(int'(run_lvl), IDLE, "R8 return wins over ack");
    chk(int'(int_req), 1, "R8 ack ignored, still offered");
    chk(int'(int_vec), 1, "R8 vector still offered");
    drain();

    // R8 deep LIFO chain
    for (int k = 0; k < N; k++) set_prio(k, 7 - k);
    for (int k = 0; k < N; k++) begin
      pulse(N'(1) << k);
      take();
      chk(int'(run_lvl), 8 - k, "R7 deep nesting level");
    end
    pulse_nmi();
    take();
    chk(int'(run_lvl), 0, "R9 nmi on top of chain");
    for (int k = 1; k <= 8; k++) begin
      ret_h();
      chk(int'(run_lvl), k, "R8 LIFO unwind");
    end
    ret_h();
    chk(int'(run_lvl), IDLE, "R8 idle at end of chain");

    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule